// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block holds the coherence state of a single line of a private cache that sits on a shared snooping bus. The line is in one of four states: Invalid, Shared, Exclusive or Modified. Two kinds of events move it between states. Local events come from the owning processor: read, write and evict. Snooped events come from other caches on the bus: bus read, bus write and bus upgrade.

For each event the block computes the next state and the action it requires. An action can be any of the following:
- issue a bus transaction,
- answer the snoop as shared,
- answer the snoop as dirty,
- write the line back,
- flag a protocol error.

Data storage, tag lookup, arbitration and memory are outside the block. Bus transactions appear only as a request/done handshake. A sharer-detect input decides how a read miss resolves.

A local request is a single-cycle pulse. The requester may present it only while the controller is idle. Snoop responses are given combinationally in the cycle the snoop is presented. State changes become visible one cycle later.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset `state_o` is Invalid, and `busy_o` and `bus_req_o` are low. The state encoding is Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R2: A local read (`loc_op_i`=00) in Invalid raises a bus read request (`bus_cmd_o`=00). In the cycle `bus_done_i` is high, the line takes Exclusive if `sharer_i` is low and Shared if it is high. A local read in any other state takes no action.
- R3: A local write (`loc_op_i`=01) in Invalid raises a bus write request (`bus_cmd_o`=01). The line becomes Modified after done.
- R4: A local write in Shared raises a bus upgrade request (`bus_cmd_o`=10). The line becomes Modified after done.
- R5: A local write in Exclusive moves the line to Modified on the next edge, with no bus request.
- R6: An eviction (`loc_op_i`=10) in Modified pulses `wb_o` and goes to Invalid. In Shared or Exclusive it goes to Invalid with no writeback.
- R7: A snooped bus read (`snp_op_i`=00) in Shared or Exclusive asserts `resp_shared_o`, and Exclusive goes to Shared. In Modified it asserts `resp_dirty_o` and `wb_o` and goes to Shared.
- R8: A snooped bus write (`snp_op_i`=01) moves Shared or Exclusive to Invalid. In Modified it asserts `resp_dirty_o` and `wb_o` and goes to Invalid.
- R9: A snooped bus upgrade (`snp_op_i`=10) moves Shared to Invalid. In Exclusive or Modified it asserts `err_o` and leaves the state unchanged.
- R10: In Invalid every snoop is ignored: no response, no error, no state change.
- R11: `busy_o` and `bus_req_o` rise the cycle after a local request needing the bus. They stay high until `bus_done_i`. The state updates on the edge after done. Local requests presented while busy are ignored. `bus_cmd_o` is 00 when there is no request.
- R12: When a snoop and a local request arrive in the same cycle, the snoop is applied first. The local request is then evaluated against the resulting state.
- R13: If a pending upgrade loses its Shared copy to a snoop, the request command changes to bus write from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_req_i | input | 1 | Local request pulse |
| loc_op_i | input | 2 | Local op: 00 read, 01 write, 10 evict |
| snp_valid_i | input | 1 | Snooped bus event valid |
| snp_op_i | input | 2 | Snoop op: 00 bus read, 01 bus write, 10 bus upgrade |
| sharer_i | input | 1 | Another cache holds the line (sampled at done) |
| bus_done_i | input | 1 | Bus transaction complete |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 2 | Requested command: 00 read, 01 write, 10 upgrade |
| busy_o | output | 1 | Local request outstanding |
| resp_shared_o | output | 1 | Snoop answered as shared |
| resp_dirty_o | output | 1 | Snoop answered as dirty |
| wb_o | output | 1 | Line data written back this cycle |
| err_o | output | 1 | Protocol error on this snoop |
| state_o | output | 2 | Current line state |

## Verification
A snoop and a local request can land in the same cycle. A snoop can also land while a bus transaction is pending or completing. The bench provokes both. It drives a bus read snoop in Modified together with a local write, and a bus write snoop in Exclusive together with a local read. It also sends an upgrade snoop against a pending upgrade. Each case is judged cycle by cycle against a reference model built from the requirements. The model applies the snoop first and then the local event.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    LOC_RD  = 2'b00,
    LOC_WR  = 2'b01,
    LOC_EVC = 2'b10,
    LOC_NOP = 2'b11
  } loc_op_e;

  typedef enum logic [1:0] {
    SNP_RD  = 2'b00,
    SNP_WR  = 2'b01,
    SNP_UPG = 2'b10,
    SNP_NOP = 2'b11
  } snp_op_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_WR  = 2'b01,
    CMD_UPG = 2'b10
  } bus_cmd_e;
endpackage

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
  import mesi_pkg::*;
(
  input  line_st_e  st_i,
  input  logic      valid_i,
  input  snp_op_e   op_i,
  output line_st_e  post_o,
  output logic      resp_shared_o,
  output logic      resp_dirty_o,
  output logic      wb_o,
  output logic      err_o
);
  always_comb begin
    post_o        = st_i;
    resp_shared_o = 1'b0;
    resp_dirty_o  = 1'b0;
    wb_o          = 1'b0;
    err_o         = 1'b0;
    if (valid_i && st_i != ST_I) begin
      unique case (op_i)
        SNP_RD: begin
          if (st_i == ST_M) begin
            resp_dirty_o = 1'b1;
            wb_o         = 1'b1;
          end else begin
            resp_shared_o = 1'b1;
          end
          post_o = ST_S;
        end
        SNP_WR: begin
          if (st_i == ST_M) begin
            resp_dirty_o = 1'b1;
            wb_o         = 1'b1;
          end
          post_o = ST_I;
        end
        SNP_UPG: begin
          // another cache cannot upgrade while this one owns the line
          if (st_i == ST_S) post_o = ST_I;
          else              err_o  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_local_eval.sv
module mesi_local_eval
  import mesi_pkg::*;
(
  input  line_st_e  st_i,
  input  logic      valid_i,
  input  loc_op_e   op_i,
  output line_st_e  next_o,
  output logic      need_bus_o,
  output logic      is_write_o,
  output logic      wb_o
);
  always_comb begin
    next_o     = st_i;
    need_bus_o = 1'b0;
    is_write_o = 1'b0;
    wb_o       = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        LOC_RD: need_bus_o = (st_i == ST_I);
        LOC_WR: begin
          is_write_o = 1'b1;
          if (st_i == ST_I || st_i == ST_S) need_bus_o = 1'b1;
          else                              next_o     = ST_M;
        end
        LOC_EVC: begin
          wb_o   = (st_i == ST_M);
          next_o = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_txn_tracker.sv
module mesi_txn_tracker
  import mesi_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      start_wr_i,
  input  logic      done_i,
  input  line_st_e  st_i,
  output logic      pend_o,
  output logic      pend_wr_o,
  output logic      complete_o,
  output bus_cmd_e  cmd_o
);
  logic pend_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
    end else if (pend_q) begin
      if (done_i) pend_q <= 1'b0;
    end else if (start_i) begin
      pend_q <= 1'b1;
      wr_q   <= start_wr_i;
    end
  end

  assign pend_o     = pend_q;
  assign pend_wr_o  = pend_q & wr_q;
  assign complete_o = pend_q & done_i;

  // a write that lost its shared copy needs the full bus write
  always_comb begin
    cmd_o = CMD_RD;
    if (pend_q && wr_q) cmd_o = (st_i == ST_S) ? CMD_UPG : CMD_WR;
  end

  p_busy_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !done_i |=> pend_q);
  p_done_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && done_i |=> !pend_q);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       loc_req_i,
  input  logic [1:0] loc_op_i,
  input  logic       snp_valid_i,
  input  logic [1:0] snp_op_i,
  input  logic       sharer_i,
  input  logic       bus_done_i,
  output logic       bus_req_o,
  output logic [1:0] bus_cmd_o,
  output logic       busy_o,
  output logic       resp_shared_o,
  output logic       resp_dirty_o,
  output logic       wb_o,
  output logic       err_o,
  output logic [1:0] state_o
);
  line_st_e state_q, state_d, snp_post, loc_next;
  logic     snp_wb, loc_wb, need_bus, loc_wr, loc_acc;
  logic     pend, pend_wr, complete;
  bus_cmd_e cmd;

  mesi_snoop_eval i_snoop (
    .st_i         (state_q),
    .valid_i      (snp_valid_i),
    .op_i         (snp_op_e'(snp_op_i)),
    .post_o       (snp_post),
    .resp_shared_o(resp_shared_o),
    .resp_dirty_o (resp_dirty_o),
    .wb_o         (snp_wb),
    .err_o        (err_o)
  );

  assign loc_acc = loc_req_i & ~pend;

  // local event sees the post-snoop state
  mesi_local_eval i_local (
    .st_i      (snp_post),
    .valid_i   (loc_acc),
    .op_i      (loc_op_e'(loc_op_i)),
    .next_o    (loc_next),
    .need_bus_o(need_bus),
    .is_write_o(loc_wr),
    .wb_o      (loc_wb)
  );

  mesi_txn_tracker i_txn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (need_bus),
    .start_wr_i(loc_wr),
    .done_i    (bus_done_i),
    .st_i      (state_q),
    .pend_o    (pend),
    .pend_wr_o (pend_wr),
    .complete_o(complete),
    .cmd_o     (cmd)
  );

  always_comb begin
    if (complete)     state_d = pend_wr ? ST_M : (sharer_i ? ST_S : ST_E);
    else if (loc_acc) state_d = loc_next;
    else              state_d = snp_post;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_I;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign busy_o    = pend;
  assign bus_req_o = pend;
  assign bus_cmd_o = cmd;
  assign wb_o      = snp_wb | loc_wb;

  p_quiet_invalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && state_o == 2'b00 |-> !resp_shared_o && !resp_dirty_o && !err_o);
  p_dirty_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_dirty_o |-> wb_o);
  p_upg_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_op_i == 2'b10 && state_o[1] |-> err_o);
  p_err_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !loc_req_i |=> state_o == $past(state_o));
  p_silent_e2m_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b10 && loc_req_i && loc_op_i == 2'b01 && !snp_valid_i && !busy_o
    |=> state_o == 2'b11 && !bus_req_o);
  p_write_done_m_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_done_i && bus_cmd_o != 2'b00 |=> state_o == 2'b11);
  p_snoop_first_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b11 && snp_valid_i && snp_op_i == 2'b00 && loc_req_i && loc_op_i == 2'b01 && !busy_o
    |=> state_o == 2'b01 && busy_o && bus_cmd_o == 2'b10);
  p_evict_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01 || state_o == 2'b10) && loc_req_i && loc_op_i == 2'b10 && !snp_valid_i && !busy_o
    |-> !wb_o ##1 state_o == 2'b00);
endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       loc_req = 0, snp_v = 0, shin = 0, done = 0;
  logic [1:0] loc_op = 0, snp_op = 0;
  logic       bus_req, busy, rs, rd, wb, err;
  logic [1:0] cmd, st;
  int total = 0, bad = 0, cyc = 0;
  bit fin = 0;

  // model state
  logic [1:0] ms = 2'b00;
  logic       mp = 0, mw = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  mesi_line_ctrl i_mesi_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .loc_req_i(loc_req), .loc_op_i(loc_op),
    .snp_valid_i(snp_v), .snp_op_i(snp_op), .sharer_i(shin), .bus_done_i(done),
    .bus_req_o(bus_req), .bus_cmd_o(cmd), .busy_o(busy), .resp_shared_o(rs),
    .resp_dirty_o(rd), .wb_o(wb), .err_o(err), .state_o(st)
  );

  // drive one cycle, push expected outputs, advance the model
  task automatic step(input logic l, input logic [1:0] lo, input logic s, input logic [1:0] so,
                      input logic sh, input logic d, input string tag);
    logic [1:0] post, ecmd;
    logic ers, erd, ewb, eerr;
    @(negedge clk);
    loc_req = l; loc_op = lo; snp_v = s; snp_op = so; shin = sh; done = d;
    #1;
    post = ms; ers = 0; erd = 0; ewb = 0; eerr = 0;
    ecmd = mp ? (mw ? (ms == 2'b01 ? 2'b10 : 2'b01) : 2'b00) : 2'b00;
    if (s && ms != 2'b00) begin
      case (so)
        2'b00: begin if (ms == 2'b11) begin erd = 1; ewb = 1; end else ers = 1; post = 2'b01; end
        2'b01: begin if (ms == 2'b11) begin erd = 1; ewb = 1; end post = 2'b00; end
        2'b10: begin if (ms == 2'b01) post = 2'b00; else eerr = 1; end
        default: ;
      endcase
    end
    exp_q.push_back({ms, mp, mp, ecmd, ers, erd, ewb, eerr});
    tag_q.push_back(tag);
    if (mp) begin
      if (d) begin ms = mw ? 2'b11 : (sh ? 2'b01 : 2'b10); mp = 0; end
      else ms = post;
    end else begin
      ms = post;
      if (l) begin
        case (lo)
          2'b00: if (post == 2'b00) begin mp = 1; mw = 0; end
          2'b01: if (post == 2'b00 || post == 2'b01) begin mp = 1; mw = 1; end
                 else ms = 2'b11;
          2'b10: begin if (post == 2'b11) exp_q[$][1] = 1'b1; ms = 2'b00; end
          default: ;
        endcase
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: pop and compare
  initial forever begin
    @(negedge clk); #2;
    while (exp_q.size() > 0) begin
      logic [9:0] e, a;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      a = {st, busy, bus_req, cmd, rs, rd, wb, err};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: {st,busy,req,cmd,rs,rd,wb,err} actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    while (!fin && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1, "R1 reset invalid");
    // R2 read miss, no sharer -> E
    step(1, 2'b00, 0, 0, 0, 0, "R2 read miss issue");
    idle(2, "R11 busy held");
    step(1, 2'b01, 0, 0, 0, 0, "R11 local ignored while busy");
    step(0, 0, 0, 0, 0, 1, "R2 done no sharer");
    idle(1, "R2 now E");
    step(1, 2'b00, 0, 0, 0, 0, "R2 read hit no action");
    step(1, 2'b10, 0, 0, 0, 0, "R6 evict E clean");
    // R2 with sharer -> S
    step(1, 2'b00, 0, 0, 0, 0, "R2 read miss issue");
    step(0, 0, 0, 0, 1, 1, "R2 done sharer");
    step(0, 0, 1, 2'b00, 0, 0, "R7 snoop read in S");
    // R4 upgrade
    step(1, 2'b01, 0, 0, 0, 0, "R4 write in S");
    step(0, 0, 0, 0, 0, 0, "R4 upgrade pending");
    step(0, 0, 0, 0, 0, 1, "R4 upgrade done");
    step(1, 2'b00, 0, 0, 0, 0, "R2 read in M no action");
    step(0, 0, 1, 2'b10, 0, 0, "R9 upgrade snoop in M err");
    step(0, 0, 1, 2'b00, 0, 0, "R7 snoop read in M dirty");
    step(0, 0, 1, 2'b01, 0, 0, "R8 snoop write in S");
    // R10 invalid ignores snoops
    step(0, 0, 1, 2'b00, 0, 0, "R10 snoop read in I");
    step(0, 0, 1, 2'b01, 0, 0, "R10 snoop write in I");
    step(0, 0, 1, 2'b10, 0, 0, "R10 snoop upgrade in I");
    // R3 write miss
    step(1, 2'b01, 0, 0, 0, 0, "R3 write miss issue");
    step(0, 0, 1, 2'b00, 0, 0, "R10 snoop during read-for-write in I");
    step(0, 0, 0, 0, 1, 1, "R3 done");
    step(0, 0, 1, 2'b01, 0, 0, "R8 snoop write in M dirty");
    // R5 silent upgrade, R6 dirty evict
    step(1, 2'b00, 0, 0, 0, 0, "R2 read miss");
    step(0, 0, 0, 0, 0, 1, "R2 done E");
    step(0, 0, 1, 2'b10, 0, 0, "R9 upgrade snoop in E err");
    step(1, 2'b01, 0, 0, 0, 0, "R5 silent E to M");
    step(1, 2'b10, 0, 0, 0, 0, "R6 evict M writeback");
    // R7 E -> S, R9 S -> I
    step(1, 2'b00, 0, 0, 0, 0, "R2 read miss");
    step(0, 0, 0, 0, 0, 1, "R2 done E");
    step(0, 0, 1, 2'b00, 0, 0, "R7 snoop read in E");
    step(0, 0, 1, 2'b10, 0, 0, "R9 upgrade snoop in S");
    // R12 same-cycle snoop and local
    step(1, 2'b01, 0, 0, 0, 0, "R3 write miss");
    step(0, 0, 0, 0, 0, 1, "R3 done M");
    step(1, 2'b01, 1, 2'b00, 0, 0, "R12 snoop read + write in M");
    step(0, 0, 0, 0, 0, 1, "R12 upgrade done");
    step(0, 0, 1, 2'b00, 0, 0, "R7 dirty to S");
    step(1, 2'b10, 0, 0, 0, 0, "R6 evict S clean");
    step(1, 2'b00, 0, 0, 0, 0, "R2 read miss");
    step(0, 0, 0, 0, 0, 1, "R2 done E");
    step(1, 2'b00, 1, 2'b01, 0, 0, "R12 snoop write + read in E");
    step(0, 0, 0, 0, 1, 1, "R12 refetch done S");
    step(1, 2'b10, 1, 2'b00, 0, 0, "R12 snoop read + evict in S");
    // R13 pending upgrade invalidated
    step(1, 2'b00, 0, 0, 0, 0, "R2 read miss");
    step(0, 0, 0, 0, 1, 1, "R2 done S");
    step(1, 2'b01, 0, 0, 0, 0, "R4 write in S");
    step(0, 0, 1, 2'b10, 0, 0, "R13 upgrade snoop on pending");
    step(0, 0, 0, 0, 0, 0, "R13 command now write");
    step(0, 0, 0, 0, 0, 1, "R13 done M");
    idle(2, "R1 idle tail");
    @(negedge clk); #3;
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule